// File: doc/BRIEF.md
# SAR Converter Control and Bus Logic

This block is the digital half of a 16-bit successive-approximation converter. It watches two active-low strobes, a chip select and a read/convert line. When both are low at once it starts a conversion. The conversion resolves one bit at a time, most significant bit first, against a single-bit comparator decision. The trial code goes out to the capacitor DAC model. The comparator result comes back as a digital input. Timing is counted in clock cycles, and a parameter sets how many cycles each bit takes.

At the end of a conversion the result is loaded into an output register in two's complement form. One cycle later a busy flag returns high. The result is presented on a parallel bus, either as a whole word or with its two byte lanes exchanged. The bus is enabled only when the chip is selected and the read/convert line is high. While a new conversion runs, the previous result stays readable for a fixed number of cycles. After that the bus is turned off until the new result is ready. A status flag records a conversion that was started back to back, with no acquisition gap.

Top module: `sar_ctrl`

## Requirements
- R1: A conversion starts on the first clock edge at which both `cs_n` and `rd_conv` are sampled low while `busy_o` is high, whichever of the two fell last; one low strobe alone never starts one.
- R2: `busy_o` is low for exactly 16*CPB+2 cycles per conversion, and the output register changes only in the cycle just before `busy_o` rises.
- R3: A start condition (both strobes low) seen while `busy_o` is low is ignored: neither the busy span nor the result is affected.
- R4: If both strobes are still low when `busy_o` rises, a new conversion starts on the next edge and `noacq_o` goes to 1; `noacq_o` returns to 0 on the next start that follows at least one idle cycle with no start condition.
- R5: `data_en_o` is 1 only when `cs_n` is 0 and `rd_conv` is 1; whenever `data_en_o` is 0, `data_o` is all zeros.
- R6: With `byte_hi` at 0, `data_o[15:8]` carries result bits 15..8 and `data_o[7:0]` carries bits 7..0; with `byte_hi` at 1 the two lanes are exchanged.
- R7: Bits are tried MSB first, starting from trial code 0x8000 (offset binary). A trial bit is kept when `cmp_i` is 1 (input at or above the trial). The result is the final trial code with its MSB inverted, so 0x7FFF is positive full scale, 0x0000 is zero, 0xFFFF is one step below zero and 0x8000 is negative full scale.
- R8: For the first PREV cycles after the start edge, a read returns the previous result. From then until `busy_o` rises, `data_en_o` is 0.
- R9: Synchronous active-high `rst` clears the output register to zero, sets `busy_o` to 1 and `noacq_o` to 0, and leaves the bus disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | High selects read, low requests a conversion |
| byte_hi | input | 1 | Exchanges the upper and lower output byte lanes |
| cmp_i | input | 1 | Comparator decision, 1 when the input is at or above the trial code |
| trial_o | output | W | Trial code to the DAC, offset binary |
| busy_o | output | 1 | Low while a conversion runs |
| noacq_o | output | 1 | Last conversion started back to back, with no acquisition gap |
| data_o | output | W | Parallel result bus, zeros when disabled |
| data_en_o | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
The bench goes after four corner cases:
- The exact edge at which the stale-data window closes (PREV-1 versus PREV cycles after the start). A design off by one here would drive the bus one cycle too long or cut the old result short.
- A start pulse injected mid-conversion. A design that fails to ignore it would restart the sequence, which lengthens the busy span and corrupts the code.
- Both strobes held low across the end of a conversion. This must restart at once and set the no-acquire flag, and a later start after an idle gap must clear it.
- The four signature codes at full scale, zero and one step below zero. These expose a missing MSB inversion or a comparator sense taken the wrong way round, and each read is taken with random lane order.

// File: rtl/sar_pkg.sv
package sar_pkg;
   // Sequencer phases
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CONV = 2'd1,
      ST_LOAD = 2'd2,
      ST_DONE = 2'd3
   } sar_state_e;
endpackage

// File: rtl/sar_decode.sv
// Strobe decode: both low requests a conversion, select low with read high reads
module sar_decode (
   input  logic cs_n,
   input  logic rd_conv,
   output logic start_req,
   output logic read_sel
);
   assign start_req = ~cs_n & ~rd_conv;
   assign read_sel  = ~cs_n &  rd_conv;
endmodule

// File: rtl/sar_seq.sv
// Successive-approximation sequencer with busy, stale-window and no-acquire tracking
module sar_seq
   import sar_pkg::*;
#(
   parameter int W    = 16,
   parameter int CPB  = 2,
   parameter int PREV = 24
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start_req,
   input  logic         cmp_i,
   output logic [W-1:0] trial_o,
   output logic         busy_o,
   output logic         noacq_o,
   output logic         load_o,
   output logic         stale_o,
   output logic [W-1:0] result_o
);
   localparam int IDX_W = $clog2(W);
   localparam int ELW   = $clog2(PREV + 1);

   sar_state_e       state;
   logic [W-1:0]     work;
   logic [IDX_W-1:0] idx;
   logic [ELW-1:0]   elapsed;
   logic [ELW-1:0]   elapsed_nx;
   logic             just_done;
   logic             tick;
   logic             start_go;

   assign start_go   = (state == ST_IDLE) && start_req;
   assign elapsed_nx = (elapsed == ELW'(PREV)) ? elapsed : elapsed + 1'b1;

   // Bit pacing: a single cycle per bit needs no divider
   generate
      if (CPB == 1) begin : g_fast
         assign tick = (state == ST_CONV);
      end else begin : g_slow
         localparam int SUB_W = $clog2(CPB);
         logic [SUB_W-1:0] sub;
         always_ff @(posedge clk) begin
            if (rst || start_go)
               sub <= '0;
            else if (state == ST_CONV)
               sub <= (sub == SUB_W'(CPB - 1)) ? '0 : sub + 1'b1;
         end
         assign tick = (state == ST_CONV) && (sub == SUB_W'(CPB - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         work      <= '0;
         idx       <= '0;
         elapsed   <= '0;
         busy_o    <= 1'b1;
         noacq_o   <= 1'b0;
         just_done <= 1'b0;
      end else begin
         just_done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_req) begin
                  state   <= ST_CONV;
                  busy_o  <= 1'b0;
                  work    <= {1'b1, {(W-1){1'b0}}};
                  idx     <= IDX_W'(W - 1);
                  elapsed <= '0;
                  noacq_o <= just_done;
               end
            end
            ST_CONV: begin
               elapsed <= elapsed_nx;
               if (tick) begin
                  if (!cmp_i)
                     work[idx] <= 1'b0;
                  if (idx != '0) begin
                     work[idx - 1'b1] <= 1'b1;
                     idx <= idx - 1'b1;
                  end else begin
                     state <= ST_LOAD;
                  end
               end
            end
            ST_LOAD: begin
               elapsed <= elapsed_nx;
               state   <= ST_DONE;
            end
            ST_DONE: begin
               busy_o    <= 1'b1;
               just_done <= 1'b1;
               state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign trial_o  = work;
   assign load_o   = (state == ST_LOAD);
   assign stale_o  = (state != ST_IDLE) && (elapsed == ELW'(PREV));
   assign result_o = {~work[W-1], work[W-2:0]};
endmodule

// File: rtl/sar_bus.sv
// Output register, byte-lane exchange and bus enable
module sar_bus #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] result,
   input  logic         read_sel,
   input  logic         stale,
   input  logic         byte_hi,
   output logic [W-1:0] q_o,
   output logic [W-1:0] data_o,
   output logic         data_en_o
);
   localparam int H = W / 2;

   logic [W-1:0] q;
   logic [W-1:0] swapped;

   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (load)
         q <= result;
   end

   generate
      for (genvar b = 0; b < W; b++) begin : g_lane
         assign swapped[b] = q[(b + H) % W];
      end
   endgenerate

   assign q_o       = q;
   assign data_en_o = read_sel & ~stale;
   assign data_o    = data_en_o ? (byte_hi ? swapped : q) : '0;
endmodule

// File: rtl/sar_ctrl.sv
// Top of the converter control section
module sar_ctrl #(
   parameter int W    = 16,
   parameter int CPB  = 2,
   parameter int PREV = 24
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cs_n,
   input  logic         rd_conv,
   input  logic         byte_hi,
   input  logic         cmp_i,
   output logic [W-1:0] trial_o,
   output logic         busy_o,
   output logic         noacq_o,
   output logic [W-1:0] data_o,
   output logic         data_en_o
);
   generate
      if (W < 2 || (W % 2) != 0) begin : g_bad_width
         $error("sar_ctrl: W must be even and at least 2");
      end
      if (CPB < 1) begin : g_bad_cpb
         $error("sar_ctrl: CPB must be at least 1");
      end
      if (PREV < 1 || PREV > W * CPB) begin : g_bad_prev
         $error("sar_ctrl: PREV must lie in 1..W*CPB");
      end
   endgenerate

   logic         start_req;
   logic         read_sel;
   logic         load;
   logic         stale;
   logic [W-1:0] result;
   logic [W-1:0] out_word;

   sar_decode u_decode (
      .cs_n      (cs_n),
      .rd_conv   (rd_conv),
      .start_req (start_req),
      .read_sel  (read_sel)
   );

   sar_seq #(.W(W), .CPB(CPB), .PREV(PREV)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start_req (start_req),
      .cmp_i     (cmp_i),
      .trial_o   (trial_o),
      .busy_o    (busy_o),
      .noacq_o   (noacq_o),
      .load_o    (load),
      .stale_o   (stale),
      .result_o  (result)
   );

   sar_bus #(.W(W)) u_bus (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .result    (result),
      .read_sel  (read_sel),
      .stale     (stale),
      .byte_hi   (byte_hi),
      .q_o       (out_word),
      .data_o    (data_o),
      .data_en_o (data_en_o)
   );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
   parameter int W   = 16,
   parameter int CPB = 2
) (
   input logic         clk,
   input logic         rst,
   input logic         cs_n,
   input logic         rd_conv,
   input logic         busy_o,
   input logic         noacq_o,
   input logic         data_en_o,
   input logic [W-1:0] trial_o,
   input logic [W-1:0] out_word
);
   logic [15:0] low_cnt;

   always_ff @(posedge clk) begin
      if (rst)
         low_cnt <= '0;
      else if (!busy_o)
         low_cnt <= low_cnt + 1'b1;
      else
         low_cnt <= '0;
   end

   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_o) |-> low_cnt == 16'(W * CPB + 2)); // R2

   AST_LOAD_BEFORE_BUSY: assert property (@(posedge clk) disable iff (rst)
      !$stable(out_word) |=> $rose(busy_o)); // R2

   AST_BUS_DESELECTED: assert property (@(posedge clk) disable iff (rst)
      cs_n |-> !data_en_o); // R5

   AST_BUS_IN_CONVERT: assert property (@(posedge clk) disable iff (rst)
      !rd_conv |-> !data_en_o); // R5

   AST_FIRST_TRIAL: assert property (@(posedge clk) disable iff (rst)
      $fell(busy_o) |-> trial_o == {1'b1, {(W-1){1'b0}}}); // R7

   AST_NOACQ_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(noacq_o) |-> $fell(busy_o) && $past(busy_o) && !$past(busy_o, 2)); // R4
endmodule

bind sar_ctrl sar_ctrl_chk #(.W(W), .CPB(CPB)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cs_n      (cs_n),
   .rd_conv   (rd_conv),
   .busy_o    (busy_o),
   .noacq_o   (noacq_o),
   .data_en_o (data_en_o),
   .trial_o   (trial_o),
   .out_word  (out_word)
);

// File: tb/sar_ctrl_bench.sv
`timescale 1ns/1ps
module sar_ctrl_bench;
   localparam int W    = 16;
   localparam int CPB  = 2;
   localparam int PREV = 24;
   localparam int LAT  = 16 * CPB + 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cs_n = 1'b1;
   logic          rd_conv = 1'b1;
   logic          byte_hi = 1'b0;
   logic          cmp;
   logic [15:0]   vin = 16'h0;
   logic [15:0]   trial;
   logic          busy;
   logic          noacq;
   logic [15:0]   data;
   logic          den;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   // Comparator model: input at or above the trial code
   assign cmp = (vin >= trial);

   sar_ctrl #(.W(W), .CPB(CPB), .PREV(PREV)) u_sar_ctrl (
      .clk       (clk),
      .rst       (rst),
      .cs_n      (cs_n),
      .rd_conv   (rd_conv),
      .byte_hi   (byte_hi),
      .cmp_i     (cmp),
      .trial_o   (trial),
      .busy_o    (busy),
      .noacq_o   (noacq),
      .data_o    (data),
      .data_en_o (den)
   );

   function automatic logic [15:0] lanes(input logic [15:0] w, input logic hi);
      return hi ? {w[7:0], w[15:8]} : w;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   // Runs one conversion from an idle negedge; optionally pokes a start mid-way
   task automatic run_conv(input logic [15:0] code, input logic [15:0] prev, input bit poke);
      vin = code ^ 16'h8000;
      cs_n = 1'b0;
      rd_conv = 1'b0;
      @(negedge clk);
      #1;
      chk(busy == 1'b0, "R1 start busy", 32'(busy), 32'd0);
      chk(noacq == 1'b0, "R4 gap clears noacq", 32'(noacq), 32'd0);
      rd_conv = 1'b1;
      byte_hi = 1'($urandom % 2);
      for (int j = 0; j <= LAT; j++) begin
         #1;
         chk(busy == 1'b0, "R2 busy low", 32'(busy), 32'd0);
         if (rd_conv) begin
            chk(den == (j < PREV), "R8 window", 32'(den), 32'(j < PREV));
            if (j < PREV)
               chk(data == lanes(prev, byte_hi), "R8 R6 prev data", 32'(data), 32'(lanes(prev, byte_hi)));
            else
               chk(data == 16'h0, "R5 off data", 32'(data), 32'd0);
         end else begin
            chk(den == 1'b0, "R5 convert", 32'(den), 32'd0);
         end
         if (poke && j == 5) rd_conv = 1'b0;   // R3 start attempt while busy
         if (poke && j == 6) rd_conv = 1'b1;
         if (rd_conv) byte_hi = 1'($urandom % 2);
         @(negedge clk);
      end
      #1;
      chk(busy == 1'b1, "R2 busy rises", 32'(busy), 32'd1);
      byte_hi = 1'b0;
      #1;
      chk(den == 1'b1, "R5 read enable", 32'(den), 32'd1);
      chk(data == code, "R7 R3 result", 32'(data), 32'(code));
      byte_hi = 1'b1;
      #1;
      chk(data == lanes(code, 1'b1), "R6 swapped", 32'(data), 32'(lanes(code, 1'b1)));
      cs_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] last;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      #1;
      chk(busy == 1'b1, "R9 busy", 32'(busy), 32'd1);
      chk(noacq == 1'b0, "R9 noacq", 32'(noacq), 32'd0);
      chk(den == 1'b0, "R9 bus off", 32'(den), 32'd0);
      rst = 1'b0;
      cs_n = 1'b0;
      rd_conv = 1'b1;
      @(negedge clk);
      #1;
      chk(den == 1'b1 && data == 16'h0, "R9 cleared reg", 32'(data), 32'd0);
      // R1: select low alone does not start
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R1 cs only", 32'(busy), 32'd1);
      run_conv(16'h7FFF, 16'h0000, 1'b0);
      // R1: convert low alone does not start
      cs_n = 1'b1;
      rd_conv = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(busy == 1'b1, "R1 rd only", 32'(busy), 32'd1);
      chk(den == 1'b0 && data == 16'h0, "R5 deselected", 32'(data), 32'd0);
      run_conv(16'h8000, 16'h7FFF, 1'b1);
      run_conv(16'h0000, 16'h8000, 1'b0);
      run_conv(16'hFFFF, 16'h0000, 1'b1);
      last = 16'hFFFF;
      for (int i = 0; i < 20; i++) begin
         logic [15:0] c;
         c = 16'($urandom);
         run_conv(c, last, 1'($urandom % 2));
         last = c;
      end
      // R4: both strobes held low across the end of a conversion
      vin = 16'h1234 ^ 16'h8000;
      cs_n = 1'b0;
      rd_conv = 1'b0;
      @(negedge clk);
      for (int j = 0; j <= LAT; j++) @(negedge clk);
      #1;
      chk(busy == 1'b1, "R4 first done", 32'(busy), 32'd1);
      chk(noacq == 1'b0, "R4 not yet", 32'(noacq), 32'd0);
      vin = 16'hA5C3 ^ 16'h8000;
      @(negedge clk);
      #1;
      chk(busy == 1'b0, "R4 immediate restart", 32'(busy), 32'd0);
      chk(noacq == 1'b1, "R4 flag set", 32'(noacq), 32'd1);
      rd_conv = 1'b1;
      byte_hi = 1'b0;
      #1;
      chk(data == 16'h1234, "R8 prev after restart", 32'(data), 32'h1234);
      for (int j = 1; j <= LAT + 1; j++) @(negedge clk);
      #1;
      chk(busy == 1'b1 && data == 16'hA5C3, "R4 second result", 32'(data), 32'hA5C3);
      chk(noacq == 1'b1, "R4 flag held", 32'(noacq), 32'd1);
      cs_n = 1'b1;
      @(negedge clk);
      run_conv(16'h0001, 16'hA5C3, 1'b0);
      rd_conv = 1'b1;
      #1;
      chk(den == 1'b0 && data == 16'h0, "R5 idle deselect", 32'(data), 32'd0);
      summary();
      $finish;
   end
endmodule